// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block starts a page read on a raw asynchronous NAND flash device. A client presents a block number, a page inside that block, a column offset and a flag that selects the spare area instead of the main data area, then pulses `start_i`. The sequencer selects the device, waits for the ready/busy line to report ready, and strobes out a command byte followed by the address bytes on an 8-bit bus. Each byte is qualified by the command-latch or address-latch enable and clocked in by a write-enable strobe. When the address phase is over, the sequencer releases both latch enables, waits for the device to finish its array fetch, and pulses `done_o`. Moving the data, correcting errors and judging bad blocks belong to other blocks.

Parameters choose the address layout. The small-page layout (512-byte pages) picks the read opcode by area. The large-page layout (2 KiB pages) always reads with the same opcode, reaches the spare area by moving the column past the page, and closes the address phase with a confirm opcode. Other parameters add one more row address cycle for large devices, and halve the column for a 16-bit device bus. Strobe width, settle time, pages per block and the ready timeout are parameters as well.

The controller is a single state machine with eight states. S_IDLE goes to S_WAIT_PRE on start. S_WAIT_PRE goes to S_SETUP once ready is seen, or to S_TIMEOUT. S_SETUP (strobe low) always goes to S_HOLD. S_HOLD (strobe high, data held) goes back to S_SETUP for the next byte, or to S_SETTLE after the last byte. S_SETTLE goes to S_WAIT_POST. S_WAIT_POST goes to S_DONE once ready is seen, or to S_TIMEOUT. S_DONE and S_TIMEOUT each last one cycle and return to S_IDLE.

Top module: `nand_read_seq`

## Requirements
- R1: After reset, and whenever `busy_o` is low: `ce_n_o`=1, `we_n_o`=1, `cle_o`=0, `ale_o`=0, `io_oe_o`=0, and `done_o` and `timeout_o` are both 0.
- R2: A `start_i` pulse is taken only while `busy_o` is low, and the operands are captured at that moment. A `start_i` seen while busy has no effect: it neither changes the bytes sent nor causes a second sequence.
- R3: After start, no write strobe is issued while `rdy_i` is low (low means busy). `cle_o` and `ale_o` are never high together.
- R4: The row address is block_i × PAGES_PER_BLOCK + page_i. Row bytes are sent low byte first.
- R5: The small-page layout sends, in order: opcode 0x00 for a main-area read or 0x50 for a spare-area read (CLE), column[7:0] (ALE), row[7:0] (ALE), row[15:8] (ALE), and, when EXTRA_ADDR=1, a byte whose low nibble is row[19:16] and whose high nibble is zero (ALE).
- R6: The large-page layout sends, in order: 0x00 (CLE), column[7:0], column[15:8], row[7:0], row[15:8] (all ALE), and, when EXTRA_ADDR=1, the nibble byte as in R5 (ALE). It then sends the confirm opcode 0x30 (CLE).
- R7: In the large-page layout, a spare-area request uses opcode 0x00 with a column of col_i + 2048.
- R8: When BUS16=1, the column is shifted right by one bit after any spare offset and before it is split into bytes.
- R9: Each byte is driven with `we_n_o` low for STROBE_CYCLES clocks, with `io_o`, `cle_o` and `ale_o` stable, and then with `we_n_o` high for STROBE_CYCLES clocks with the data still held. The device latches the byte on the rising edge of `we_n_o`.
- R10: After the last byte, `cle_o` and `ale_o` are both low. The block waits SETTLE_CYCLES clocks and then for `rdy_i` high, then raises `done_o` for exactly one cycle and deasserts `ce_n_o`.
- R11: If `rdy_i` stays low for TIMEOUT_CYCLES clocks in either ready wait, `timeout_o` pulses for one cycle, `done_o` is not raised, and the block returns to idle with `ce_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a page read (taken when idle) |
| block_i | input | BLOCK_W | Erase block number |
| page_i | input | PAGE_W | Page within the block |
| col_i | input | COL_W | Column byte offset |
| spare_i | input | 1 | 1 = read the spare area, 0 = main area |
| rdy_i | input | 1 | Device ready/busy line, 1 = ready |
| io_o | output | 8 | Command/address byte |
| io_oe_o | output | 1 | Output enable for io_o |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| ce_n_o | output | 1 | Chip enable, active low |
| we_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: page ready for transfer |
| timeout_o | output | 1 | One-cycle pulse: ready wait expired |

## Verification
The hardest situations to reach are those that depend on the device's ready line at particular points. These are a device that is still busy when a request arrives, a busy period that never ends either before the command or after the address phase, and a second start arriving partway through the address bytes. The bench drives the ready line from its own device model. That model can hold the line low on demand, and after it latches the expected number of bytes it holds the line busy for a chosen length. This lets a stuck-busy device be set up for either wait, and a stray start be injected a fixed number of cycles into a sequence. Three configurations (large-page with five address bytes, small-page with the extra row byte, and large-page on a 16-bit bus) are swept over block, page, column and area, and every latched byte is compared with a value computed arithmetically.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_PRE,
        S_SETUP,
        S_HOLD,
        S_SETTLE,
        S_WAIT_POST,
        S_DONE,
        S_TIMEOUT
    } seq_state_t;

    typedef enum logic {
        LAT_CMD,
        LAT_ADDR
    } latch_kind_t;

    localparam logic [7:0] OP_READ        = 8'h00;
    localparam logic [7:0] OP_CONFIRM     = 8'h30;
    localparam logic [7:0] OP_SPARE_SMALL = 8'h50;

endpackage

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (count != {CNT_W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
    import nand_seq_pkg::*;
#(
    parameter int LARGE_PAGE      = 1,
    parameter int EXTRA_ADDR      = 0,
    parameter int BUS16           = 0,
    parameter int BLOCK_W         = 12,
    parameter int PAGE_W          = 6,
    parameter int COL_W           = 12,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int STEP_W          = 3
) (
    input  logic [BLOCK_W-1:0] block_i,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [COL_W-1:0]   col_i,
    input  logic               spare_i,
    input  logic [STEP_W-1:0]  step_i,
    output logic [7:0]         byte_o,
    output latch_kind_t        kind_o,
    output logic               last_o
);
    localparam int ROW_W      = 20;
    localparam int PAGE_BYTES = (LARGE_PAGE != 0) ? 2048 : 512;
    localparam int NSTEP      = (LARGE_PAGE != 0) ? (6 + EXTRA_ADDR) : (4 + EXTRA_ADDR);

    logic [ROW_W-1:0] row;
    logic [15:0]      col_off;
    logic [15:0]      col_wire;
    logic             unused_bits;

    assign row = ROW_W'(block_i) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(page_i);

    always_comb begin
        col_off = 16'(col_i);
        if ((LARGE_PAGE != 0) && spare_i) begin
            col_off = col_off + 16'(PAGE_BYTES);
        end
    end

    generate
        if (BUS16 != 0) begin : g_word_bus
            assign col_wire = col_off >> 1;
        end else begin : g_byte_bus
            assign col_wire = col_off;
        end
    endgenerate

    assign last_o      = (step_i == STEP_W'(NSTEP - 1));
    assign unused_bits = ^{col_wire, row};

    generate
        if (LARGE_PAGE != 0) begin : g_large
            always_comb begin
                byte_o = 8'h00;
                kind_o = LAT_ADDR;
                case (step_i)
                    STEP_W'(0): begin byte_o = OP_READ;        kind_o = LAT_CMD; end
                    STEP_W'(1): byte_o = col_wire[7:0];
                    STEP_W'(2): byte_o = col_wire[15:8];
                    STEP_W'(3): byte_o = row[7:0];
                    STEP_W'(4): byte_o = row[15:8];
                    STEP_W'(5): begin
                        if (EXTRA_ADDR != 0) begin
                            byte_o = {4'h0, row[19:16]};
                        end else begin
                            byte_o = OP_CONFIRM;
                            kind_o = LAT_CMD;
                        end
                    end
                    default: begin byte_o = OP_CONFIRM;   kind_o = LAT_CMD; end
                endcase
            end
        end else begin : g_small
            always_comb begin
                byte_o = 8'h00;
                kind_o = LAT_ADDR;
                case (step_i)
                    STEP_W'(0): begin
                        byte_o = spare_i ? OP_SPARE_SMALL : OP_READ;
                        kind_o = LAT_CMD;
                    end
                    STEP_W'(1): byte_o = col_wire[7:0];
                    STEP_W'(2): byte_o = row[7:0];
                    STEP_W'(3): byte_o = row[15:8];
                    default:    byte_o = {4'h0, row[19:16]};
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
    import nand_seq_pkg::*;
#(
    parameter int LARGE_PAGE      = 1,
    parameter int EXTRA_ADDR      = 0,
    parameter int BUS16           = 0,
    parameter int BLOCK_W         = 12,
    parameter int PAGE_W          = 6,
    parameter int COL_W           = 12,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int STROBE_CYCLES   = 2,
    parameter int SETTLE_CYCLES   = 2,
    parameter int TIMEOUT_CYCLES  = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BLOCK_W-1:0] block_i,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [COL_W-1:0]   col_i,
    input  logic               spare_i,
    input  logic               rdy_i,
    output logic [7:0]         io_o,
    output logic               io_oe_o,
    output logic               cle_o,
    output logic               ale_o,
    output logic               ce_n_o,
    output logic               we_n_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               timeout_o
);
    localparam int STEP_W = 3;
    localparam int CNT_W  = $clog2(TIMEOUT_CYCLES + STROBE_CYCLES + SETTLE_CYCLES + 2);

    seq_state_t         state_q, state_d;
    logic [STEP_W-1:0]  step_q;
    logic [BLOCK_W-1:0] block_q;
    logic [PAGE_W-1:0]  page_q;
    logic [COL_W-1:0]   col_q;
    logic               spare_q;
    logic [CNT_W-1:0]   cnt;
    logic [7:0]         cur_byte;
    latch_kind_t        cur_kind;
    logic               cur_last;
    logic               strobe_end, settle_end, wait_expired;

    nand_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state_q),
        .count (cnt)
    );

    nand_addr_gen #(
        .LARGE_PAGE      (LARGE_PAGE),
        .EXTRA_ADDR      (EXTRA_ADDR),
        .BUS16           (BUS16),
        .BLOCK_W         (BLOCK_W),
        .PAGE_W          (PAGE_W),
        .COL_W           (COL_W),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
        .STEP_W          (STEP_W)
    ) u_addr (
        .block_i (block_q),
        .page_i  (page_q),
        .col_i   (col_q),
        .spare_i (spare_q),
        .step_i  (step_q),
        .byte_o  (cur_byte),
        .kind_o  (cur_kind),
        .last_o  (cur_last)
    );

    assign strobe_end   = (cnt == CNT_W'(STROBE_CYCLES - 1));
    assign settle_end   = (cnt == CNT_W'(SETTLE_CYCLES - 1));
    assign wait_expired = (cnt == CNT_W'(TIMEOUT_CYCLES - 1));

    // State register, byte index and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            block_q <= '0;
            page_q  <= '0;
            col_q   <= '0;
            spare_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                step_q  <= '0;
                block_q <= block_i;
                page_q  <= page_i;
                col_q   <= col_i;
                spare_q <= spare_i;
            end else if (state_q == S_HOLD && strobe_end && !cur_last) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start_i) state_d = S_WAIT_PRE;
            S_WAIT_PRE: begin
                if (rdy_i)             state_d = S_SETUP;
                else if (wait_expired) state_d = S_TIMEOUT;
            end
            S_SETUP:     if (strobe_end) state_d = S_HOLD;
            S_HOLD: begin
                if (strobe_end) state_d = cur_last ? S_SETTLE : S_SETUP;
            end
            S_SETTLE:    if (settle_end) state_d = S_WAIT_POST;
            S_WAIT_POST: begin
                if (rdy_i)             state_d = S_DONE;
                else if (wait_expired) state_d = S_TIMEOUT;
            end
            S_DONE:      state_d = S_IDLE;
            S_TIMEOUT:   state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        io_o      = 8'h00;
        io_oe_o   = 1'b0;
        cle_o     = 1'b0;
        ale_o     = 1'b0;
        ce_n_o    = 1'b1;
        we_n_o    = 1'b1;
        busy_o    = (state_q != S_IDLE);
        done_o    = (state_q == S_DONE);
        timeout_o = (state_q == S_TIMEOUT);
        unique case (state_q)
            S_WAIT_PRE, S_SETTLE, S_WAIT_POST: ce_n_o = 1'b0;
            S_SETUP, S_HOLD: begin
                ce_n_o  = 1'b0;
                io_oe_o = 1'b1;
                io_o    = cur_byte;
                cle_o   = (cur_kind == LAT_CMD);
                ale_o   = (cur_kind == LAT_ADDR);
                we_n_o  = (state_q == S_HOLD);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_read_seq_chk.sv
module nand_read_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       rdy_i,
    input logic [7:0] io_o,
    input logic       io_oe_o,
    input logic       cle_o,
    input logic       ale_o,
    input logic       ce_n_o,
    input logic       we_n_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       timeout_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (we_n_o && ce_n_o && !cle_o && !ale_o && !io_oe_o)); // R1

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o)); // R3

    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> (!ce_n_o && io_oe_o)); // R9

    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n_o && $past(!we_n_o)) |-> ($stable(io_o) && $stable(cle_o) && $stable(ale_o))); // R9

    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(rdy_i) && !cle_o && !ale_o)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && ce_n_o)); // R10

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o)); // R11

    AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (!timeout_o && ce_n_o && !busy_o)); // R11
endmodule

bind nand_read_seq nand_read_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rdy_i     (rdy_i),
    .io_o      (io_o),
    .io_oe_o   (io_oe_o),
    .cle_o     (cle_o),
    .ale_o     (ale_o),
    .ce_n_o    (ce_n_o),
    .we_n_o    (we_n_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
);

// File: tb/tb_nand_read_seq.sv
module tb_nand_model (
    input  logic       clk,
    input  logic       clr,
    input  logic       force_low,
    input  int         exp_n,
    input  int         busy_len,
    input  logic       we_n,
    input  logic       cle,
    input  logic       ale,
    input  logic [7:0] io,
    output logic       rdy
);
    logic [9:0] log_q [0:15];
    int         n;
    int         busy;
    int         lowc;
    int         wmin, wmax;
    logic       weq;

    always @(posedge clk) begin
        if (clr) begin
            n <= 0; busy <= 0; lowc <= 0; wmin <= 999; wmax <= 0; weq <= 1'b1;
        end else begin
            weq <= we_n;
            if (!we_n) lowc <= lowc + 1;
            if (busy != 0) busy <= busy - 1;
            if (!weq && we_n) begin
                if (n < 16) log_q[n] <= {cle, ale, io};
                n <= n + 1;
                lowc <= 0;
                if (lowc < wmin) wmin <= lowc;
                if (lowc > wmax) wmax <= lowc;
                if (n + 1 == exp_n) busy <= busy_len;
            end
        end
    end

    assign rdy = (busy == 0) && !force_low;
endmodule

module tb_lane #(
    parameter int LARGE = 1,
    parameter int EXTRA = 1,
    parameter int BUS16 = 0,
    parameter int ID    = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output int   errs,
    output int   chks,
    output logic fin
);
    localparam int PPB = 64;
    localparam int STROBE = 2;
    localparam int TMO = 200;

    logic        start_i, spare_i, rdy_i;
    logic [11:0] block_i, col_i;
    logic [5:0]  page_i;
    logic [7:0]  io_o;
    logic        io_oe_o, cle_o, ale_o, ce_n_o, we_n_o, busy_o, done_o, timeout_o;
    logic        clr, force_low;
    int          exp_n, busy_len;

    nand_read_seq #(
        .LARGE_PAGE(LARGE), .EXTRA_ADDR(EXTRA), .BUS16(BUS16),
        .BLOCK_W(12), .PAGE_W(6), .COL_W(12), .PAGES_PER_BLOCK(PPB),
        .STROBE_CYCLES(STROBE), .SETTLE_CYCLES(2), .TIMEOUT_CYCLES(TMO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i),
        .page_i(page_i), .col_i(col_i), .spare_i(spare_i), .rdy_i(rdy_i),
        .io_o(io_o), .io_oe_o(io_oe_o), .cle_o(cle_o), .ale_o(ale_o),
        .ce_n_o(ce_n_o), .we_n_o(we_n_o), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o)
    );

    tb_nand_model u_model (
        .clk(clk), .clr(clr), .force_low(force_low), .exp_n(exp_n),
        .busy_len(busy_len), .we_n(we_n_o), .cle(cle_o), .ale(ale_o),
        .io(io_o), .rdy(rdy_i)
    );

    logic [9:0] ex [0:7];
    int         ne;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s lane%0d: actual=%0h expected=%0h", tag, ID, act, expv);
        end
    endtask

    task automatic expect_seq(input int b, input int p, input int c, input bit s);
        int row, colv;
        row  = b * PPB + p;
        colv = c;
        if (LARGE != 0 && s) colv = colv + 2048;
        if (BUS16 != 0) colv = colv >> 1;
        ne = 0;
        if (LARGE != 0) begin
            ex[0] = {2'b10, 8'h00};
            ex[1] = {2'b01, 8'(colv)};
            ex[2] = {2'b01, 8'(colv >> 8)};
            ex[3] = {2'b01, 8'(row)};
            ex[4] = {2'b01, 8'(row >> 8)};
            ne = 5;
            if (EXTRA != 0) begin ex[5] = {2'b01, 4'h0, 4'(row >> 16)}; ne = 6; end
            ex[ne] = {2'b10, 8'h30};
            ne = ne + 1;
        end else begin
            ex[0] = {2'b10, (s ? 8'h50 : 8'h00)};
            ex[1] = {2'b01, 8'(colv)};
            ex[2] = {2'b01, 8'(row)};
            ex[3] = {2'b01, 8'(row >> 8)};
            ne = 4;
            if (EXTRA != 0) begin ex[4] = {2'b01, 4'h0, 4'(row >> 16)}; ne = 5; end
        end
    endtask

    task automatic launch(input int b, input int p, input int c, input bit s);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        exp_n   = ne;
        block_i = 12'(b); page_i = 6'(p); col_i = 12'(c); spare_i = s;
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // Waits for done or timeout; returns 1 for done, 2 for timeout, 0 for neither
    task automatic wait_end(output int how, output int cyc, input bit stray);
        how = 0;
        cyc = 0;
        while (how == 0 && cyc < 3000) begin
            if (done_o) how = 1;
            else if (timeout_o) how = 2;
            else begin
                if (stray && cyc == 7) begin
                    block_i = ~block_i; page_i = ~page_i; col_i = ~col_i; spare_i = ~spare_i;
                    start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        start_i = 1'b0;
    endtask

    task automatic compare_log(input string tag);
        check(u_model.n == ne, {tag, " byte count"}, u_model.n, ne);
        for (int i = 0; i < ne; i++) begin
            check(u_model.log_q[i] == ex[i], {tag, " latched byte"}, int'(u_model.log_q[i]), int'(ex[i]));
        end
        check(u_model.wmin == STROBE && u_model.wmax == STROBE, "R9 strobe low width",
              u_model.wmin * 100 + u_model.wmax, STROBE * 101);
    endtask

    task automatic txn(input int b, input int p, input int c, input bit s, input bit stray);
        int how, cyc;
        string tag;
        tag = (LARGE != 0) ? (s ? "R7/R6/R4" : "R6/R4") : "R5/R4";
        if (BUS16 != 0) tag = {tag, "/R8"};
        if (stray) tag = {tag, "/R2"};
        expect_seq(b, p, c, s);
        launch(b, p, c, s);
        wait_end(how, cyc, stray);
        check(how == 1, "R10 done pulse", how, 1);
        compare_log(tag);
        @(negedge clk);
        check(ce_n_o && !busy_o && !done_o, "R10 release after done",
              {ce_n_o, busy_o, done_o}, 3'b100);
        if (stray) begin
            repeat (20) @(negedge clk);
            check(u_model.n == ne && !busy_o, "R2 no second sequence", u_model.n, ne);
        end
    endtask

    int bl [0:3] = '{0, 1, 37, 4095};
    int pg [0:2] = '{0, 5, 63};
    int cl [0:2] = '{0, 'h1AB, 'hFFF};

    initial begin
        int how, cyc, lows;
        errs = 0; chks = 0; fin = 1'b0;
        start_i = 0; spare_i = 0; block_i = 0; page_i = 0; col_i = 0;
        clr = 1'b1; force_low = 1'b0; exp_n = 99; busy_len = 20;
        wait (go);
        @(negedge clk);
        // R1 reset state
        check(ce_n_o && we_n_o && !cle_o && !ale_o && !io_oe_o && !busy_o && !done_o && !timeout_o,
              "R1 reset outputs", {ce_n_o, we_n_o, cle_o, ale_o, io_oe_o, busy_o, done_o, timeout_o},
              8'b1100_0000);
        clr = 1'b0;

        // Sweep over block, page, column and area
        for (int bi = 0; bi < 4; bi++)
            for (int pi = 0; pi < 3; pi++)
                for (int ci = 0; ci < 3; ci++)
                    for (int s = 0; s < 2; s++)
                        txn(bl[bi], pg[pi], cl[ci], s[0], 1'b0);

        // R2: a start pulse in the middle of the address phase is ignored
        txn(37, 5, 'h1AB, 1'b0, 1'b1);
        txn(4095, 63, 'h0FF, 1'b1, 1'b1);

        // R3: device busy when the request arrives
        expect_seq(1, 2, 3, 1'b0);
        force_low = 1'b1;
        launch(1, 2, 3, 1'b0);
        lows = 0;
        for (int k = 0; k < 40; k++) begin
            if (!we_n_o) lows++;
            @(negedge clk);
        end
        check(lows == 0 && u_model.n == 0 && !ce_n_o, "R3 no strobe while busy", lows, 0);
        force_low = 1'b0;
        wait_end(how, cyc, 1'b0);
        check(how == 1, "R3 proceeds once ready", how, 1);
        compare_log((LARGE != 0) ? "R3/R6" : "R3/R5");

        // R11: ready never comes before the command
        expect_seq(2, 3, 4, 1'b0);
        force_low = 1'b1;
        launch(2, 3, 4, 1'b0);
        wait_end(how, cyc, 1'b0);
        check(how == 2, "R11 timeout before command", how, 2);
        check(cyc >= TMO - 2 && cyc <= TMO + 2, "R11 timeout latency", cyc, TMO);
        check(u_model.n == 0, "R11 no bytes sent", u_model.n, 0);
        @(negedge clk);
        check(ce_n_o && !busy_o && !done_o, "R11 idle after timeout", {ce_n_o, busy_o, done_o}, 3'b100);
        force_low = 1'b0;

        // R11: device stays busy after the address phase
        busy_len = 600;
        expect_seq(5, 6, 7, 1'b1);
        launch(5, 6, 7, 1'b1);
        wait_end(how, cyc, 1'b0);
        check(how == 2, "R11 timeout after address", how, 2);
        check(u_model.n == ne, "R11 address sent before timeout", u_model.n, ne);
        @(negedge clk);
        check(ce_n_o && !busy_o, "R11 idle after late timeout", {ce_n_o, busy_o}, 2'b10);
        busy_len = 20;
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        fin = 1'b1;
    end
endmodule

module tb_nand_read_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    int   e0, c0, e1, c1, e2, c2;
    logic f0, f1, f2;
    int   cycles = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    tb_lane #(.LARGE(1), .EXTRA(1), .BUS16(0), .ID(0)) u_lane0 (
        .clk(clk), .rst_n(rst_n), .go(go), .errs(e0), .chks(c0), .fin(f0));
    tb_lane #(.LARGE(0), .EXTRA(1), .BUS16(0), .ID(1)) u_lane1 (
        .clk(clk), .rst_n(rst_n), .go(go), .errs(e1), .chks(c1), .fin(f1));
    tb_lane #(.LARGE(1), .EXTRA(0), .BUS16(1), .ID(2)) u_lane2 (
        .clk(clk), .rst_n(rst_n), .go(go), .errs(e2), .chks(c2), .fin(f2));

    initial begin
        int errs, chks;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        go = 1'b1;
        while (!(f0 && f1 && f2) && cycles < 150000) @(negedge clk);
        errs = e0 + e1 + e2;
        chks = c0 + c1 + c2;
        if (!(f0 && f1 && f2)) begin
            errs++;
            chks++;
            $display("FAIL watchdog: actual=%0d expected=below %0d cycles", cycles, 150000);
        end
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end
endmodule